// File: doc/BRIEF.md
# Paged I/O Window Decoder

This block decodes host accesses to a 32-byte I/O region in which one narrow 16-byte data window is shared by several internal units. The host first writes a page number into an index register. Every later access that falls inside the window then goes to the unit that the page number names.

The units are two HDLC channels and a line transceiver. Each HDLC channel has a FIFO data port and a 32-bit status/control port. The transceiver has a FIFO port and a register space that is split into a low page and a high page. The block drives one select strobe per unit, a 4-bit local offset, and the multiplexed read data. The units are modelled as small register stubs, so every path can be written and read back.

A flat map mode is chosen with a static input. In that mode each HDLC port has a fixed address. The transceiver is then reached through an index/data pair: the hardware picks the page and the local offset from the transceiver's logical register number.

Top module: `iowin_decoder`

## Requirements
- R1: After reset the index register reads 0x00 and every unit stub reads zero.
- R2: In both modes, a write to byte address 0x04 loads the index register from write data bits [7:0]. A read of 0x04 returns the index zero-extended to 32 bits. An access to any other address leaves the index unchanged.
- R3: In indexed mode, page 0x00 selects HDLC channel 1 and page 0x01 selects channel 2. Within the window (0x10 to 0x1F), window offset 0 reaches that channel's 32-bit FIFO port and window offset 4 reaches its 32-bit status/control port.
- R4: In indexed mode, page 0x02 routes every window offset to the transceiver FIFO port. This port holds 8 bits, and reads return it zero-extended.
- R5: In indexed mode, page 0x04 routes the window to the transceiver low page and page 0x06 routes it to the high page. The local offset is address bits [3:0]. Each page holds 16 separate 8-bit registers.
- R6: Every unassigned page, every window offset other than 0 or 4 on an HDLC page, and every region address with no listed function reads 0xFFFFFFFF. Such an access raises no strobe, and a write to it changes no stored value.
- R7: In flat mode, the index value has no effect on the HDLC ports. Channel 1 FIFO is at 0x10 and its status/control port at 0x14. Channel 2 FIFO is at 0x18 and its status/control port at 0x1C. The local offset is 0 for a FIFO port and 4 for a status/control port.
- R8: In flat mode, an access to 0x08 reaches the transceiver register whose logical number is held in the index register. A logical number of 0x30 or above selects the high page; a lower number selects the low page. The local offset is the number's bits [3:0]. Only write data bits [7:0] are stored, and reads return the byte zero-extended.
- R9: In both modes, byte addresses 0x02 and 0x03 reach two separate 8-bit card control bytes, with local offsets 2 and 3.
- R10: At most one strobe is high at a time, and strobes rise only during an access. While a strobe is high, the local offset equals the offset stated for that route. When no unit is selected, the offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flat_map | input | 1 | 1 selects the flat map, 0 the indexed window |
| acc_valid | input | 1 | An access is present this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 5 | Byte address within the region |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational from the address |
| hdlc_fifo_stb | output | 2 | FIFO port strobe per HDLC channel |
| hdlc_ctl_stb | output | 2 | Status/control port strobe per HDLC channel |
| xcv_lo_stb | output | 1 | Transceiver low page strobe |
| xcv_hi_stb | output | 1 | Transceiver high page strobe |
| xcv_fifo_stb | output | 1 | Transceiver FIFO strobe |
| card_stb | output | 1 | Card control byte strobe |
| unit_off | output | 4 | Local offset presented to the selected unit |

## Verification
The bench aims at the following edge cases:
- **Page boundary at logical register 0x2F/0x30.** A comparison off by one would send register 0x2F to the high page, or 0x30 to the low page.
- **Stray HDLC window offsets**, such as 0x11 or 0x18 on an HDLC page. A decoder that looked at too few address bits would alias these offsets onto the FIFO or the status port and corrupt them.
- **Unassigned page values 0x03 and 0x05.** A decoder that checked only some of the index bits would treat these as a neighbouring page.
- **Index ignored in flat mode.** Flat accesses to the HDLC ports are made while the index holds a transceiver page. A design that still consulted the index would misroute them.
- **Shared storage between the two views.** Values written through the indexed window are read back through the flat index/data pair. This exposes any page or offset swap between the two modes.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  localparam int OFF_W           = 4;
  localparam int NUM_UNITS       = 8;

  // region byte addresses
  localparam int CARD_ADDR_A     = 2;
  localparam int CARD_ADDR_B     = 3;
  localparam int IDX_ADDR        = 4;
  localparam int FLAT_XDATA_ADDR = 8;
  localparam int WIN_BASE        = 16;
  localparam int FLAT_H1_FIFO    = 16;
  localparam int FLAT_H1_CTL     = 20;
  localparam int FLAT_H2_FIFO    = 24;
  localparam int FLAT_H2_CTL     = 28;

  // offsets inside an HDLC channel
  localparam int HDLC_FIFO_OFF   = 0;
  localparam int HDLC_CTL_OFF    = 4;

  // page numbers written to the index register
  localparam int PAGE_H1         = 0;
  localparam int PAGE_H2         = 1;
  localparam int PAGE_XFIFO      = 2;
  localparam int PAGE_XLO        = 4;
  localparam int PAGE_XHI        = 6;

  // first transceiver logical register that lives in the high page
  localparam int HIGH_PAGE_FIRST = 'h30;

  typedef enum logic [3:0] {
    TGT_NONE    = 4'd0,
    TGT_CARD    = 4'd1,
    TGT_H1_FIFO = 4'd2,
    TGT_H1_CTL  = 4'd3,
    TGT_H2_FIFO = 4'd4,
    TGT_H2_CTL  = 4'd5,
    TGT_X_LO    = 4'd6,
    TGT_X_HI    = 4'd7,
    TGT_X_FIFO  = 4'd8,
    TGT_INDEX   = 4'd9
  } tgt_e;

  // unit u is selected by target code u+1
  function automatic int unit_width(input int u);
    case (u)
      1, 2, 3, 4: return 32;
      default:    return 8;
    endcase
  endfunction

  function automatic int unit_depth(input int u);
    case (u)
      0:       return 2;
      5, 6:    return 16;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/iowin_addr_decode.sv
module iowin_addr_decode
  import iowin_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 8
) (
  input  logic              acc_valid,
  input  logic              flat_map,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [IDX_W-1:0]  idx_q,
  output tgt_e              tgt,
  output logic [OFF_W-1:0]  off
);

  localparam int WIN_HI_W = ADDR_W - OFF_W;

  logic             in_window;
  logic [OFF_W-1:0] woff;

  assign in_window = (acc_addr[ADDR_W-1:OFF_W] == WIN_HI_W'(WIN_BASE >> OFF_W));
  assign woff      = acc_addr[OFF_W-1:0];

  always_comb begin
    tgt = TGT_NONE;
    off = '0;
    if (acc_valid) begin
      if (acc_addr == ADDR_W'(CARD_ADDR_A) || acc_addr == ADDR_W'(CARD_ADDR_B)) begin
        tgt = TGT_CARD;
        off = woff;
      end else if (acc_addr == ADDR_W'(IDX_ADDR)) begin
        tgt = TGT_INDEX;
      end else if (flat_map) begin
        if (acc_addr == ADDR_W'(FLAT_XDATA_ADDR)) begin
          tgt = (idx_q >= IDX_W'(HIGH_PAGE_FIRST)) ? TGT_X_HI : TGT_X_LO;
          off = idx_q[OFF_W-1:0];
        end else if (acc_addr == ADDR_W'(FLAT_H1_FIFO)) begin
          tgt = TGT_H1_FIFO;
          off = OFF_W'(HDLC_FIFO_OFF);
        end else if (acc_addr == ADDR_W'(FLAT_H1_CTL)) begin
          tgt = TGT_H1_CTL;
          off = OFF_W'(HDLC_CTL_OFF);
        end else if (acc_addr == ADDR_W'(FLAT_H2_FIFO)) begin
          tgt = TGT_H2_FIFO;
          off = OFF_W'(HDLC_FIFO_OFF);
        end else if (acc_addr == ADDR_W'(FLAT_H2_CTL)) begin
          tgt = TGT_H2_CTL;
          off = OFF_W'(HDLC_CTL_OFF);
        end
      end else if (in_window) begin
        if (idx_q == IDX_W'(PAGE_H1)) begin
          if (woff == OFF_W'(HDLC_FIFO_OFF))     tgt = TGT_H1_FIFO;
          else if (woff == OFF_W'(HDLC_CTL_OFF)) tgt = TGT_H1_CTL;
        end else if (idx_q == IDX_W'(PAGE_H2)) begin
          if (woff == OFF_W'(HDLC_FIFO_OFF))     tgt = TGT_H2_FIFO;
          else if (woff == OFF_W'(HDLC_CTL_OFF)) tgt = TGT_H2_CTL;
        end else if (idx_q == IDX_W'(PAGE_XFIFO)) begin
          tgt = TGT_X_FIFO;
        end else if (idx_q == IDX_W'(PAGE_XLO)) begin
          tgt = TGT_X_LO;
        end else if (idx_q == IDX_W'(PAGE_XHI)) begin
          tgt = TGT_X_HI;
        end
        if (tgt != TGT_NONE) off = woff;
      end
    end
  end

endmodule

// File: rtl/iowin_unit_stub.sv
module iowin_unit_stub
  import iowin_pkg::*;
#(
  parameter int UW     = 8,
  parameter int DEPTH  = 1,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic          unused_bits;
  logic [UW-1:0] rd_val;

  assign unused_bits = ^{off, wdata};

  generate
    if (DEPTH == 1) begin : g_single
      logic [UW-1:0] val_q, val_d;

      always_comb begin
        val_d = val_q;
        if (wr_en) val_d = wdata[UW-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
      end

      assign rd_val = val_q;
    end else begin : g_array
      localparam int AW = $clog2(DEPTH);
      logic [UW-1:0] mem_q [DEPTH];
      logic [AW-1:0] slot;

      assign slot = off[AW-1:0];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
          mem_q[slot] <= wdata[UW-1:0];
        end
      end

      assign rd_val = mem_q[slot];
    end
  endgenerate

  always_comb begin
    rdata           = '0;
    rdata[UW-1:0]   = rd_val;
  end

endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
  import iowin_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flat_map,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic [1:0]        hdlc_fifo_stb,
  output logic [1:0]        hdlc_ctl_stb,
  output logic              xcv_lo_stb,
  output logic              xcv_hi_stb,
  output logic              xcv_fifo_stb,
  output logic              card_stb,
  output logic [OFF_W-1:0]  unit_off
);

  tgt_e                 tgt;
  logic [OFF_W-1:0]     off;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic                 idx_wr;
  logic [NUM_UNITS-1:0] unit_stb;
  logic [NUM_UNITS-1:0] unit_wr;
  logic [DATA_W-1:0]    unit_rd [NUM_UNITS];
  logic [DATA_W-1:0]    rd_mux;

  iowin_addr_decode #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_dec (
    .acc_valid (acc_valid),
    .flat_map  (flat_map),
    .acc_addr  (acc_addr),
    .idx_q     (idx_q),
    .tgt       (tgt),
    .off       (off)
  );

  // index register: next state and register
  assign idx_wr = acc_write && (tgt == TGT_INDEX);

  always_comb begin
    idx_d = idx_q;
    if (idx_wr) idx_d = acc_wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // one stub per addressable unit
  generate
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      assign unit_stb[u] = (tgt == tgt_e'(u + 1));
      assign unit_wr[u]  = unit_stb[u] & acc_write;

      iowin_unit_stub #(
        .UW     (unit_width(u)),
        .DEPTH  (unit_depth(u)),
        .DATA_W (DATA_W)
      ) u_stub (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (unit_wr[u]),
        .off   (off),
        .wdata (acc_wdata),
        .rdata (unit_rd[u])
      );
    end
  endgenerate

  // read data multiplexer; unmapped reads float high
  always_comb begin
    rd_mux = '1;
    if (tgt == TGT_INDEX) begin
      rd_mux             = '0;
      rd_mux[IDX_W-1:0]  = idx_q;
    end
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (unit_stb[u]) rd_mux = unit_rd[u];
    end
  end

  assign acc_rdata     = rd_mux;
  assign card_stb      = unit_stb[0];
  assign hdlc_fifo_stb = {unit_stb[3], unit_stb[1]};
  assign hdlc_ctl_stb  = {unit_stb[4], unit_stb[2]};
  assign xcv_lo_stb    = unit_stb[5];
  assign xcv_hi_stb    = unit_stb[6];
  assign xcv_fifo_stb  = unit_stb[7];
  assign unit_off      = off;

  // checks
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdlc_fifo_stb, hdlc_ctl_stb, xcv_lo_stb, xcv_hi_stb, xcv_fifo_stb, card_stb})); // R10

  AST_STROBE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (|{hdlc_fifo_stb, hdlc_ctl_stb, xcv_lo_stb, xcv_hi_stb, xcv_fifo_stb, card_stb}) |-> acc_valid); // R10

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr == ADDR_W'(IDX_ADDR)) |=> (idx_q == $past(acc_wdata[IDX_W-1:0]))); // R2

  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write && acc_addr == ADDR_W'(IDX_ADDR)) |=> $stable(idx_q)); // R2

  AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && unit_stb == '0 && tgt != TGT_INDEX) |-> (acc_rdata == '1)); // R6

  AST_FLAT_CH2_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && flat_map && acc_addr == ADDR_W'(FLAT_H2_FIFO)) |-> hdlc_fifo_stb[1]); // R7

  AST_FLAT_HIGH_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && flat_map && acc_addr == ADDR_W'(FLAT_XDATA_ADDR) &&
     idx_q >= IDX_W'(HIGH_PAGE_FIRST)) |-> xcv_hi_stb); // R8

endmodule

// File: tb/iowin_decoder_test.sv
module iowin_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flat_map;
  logic        acc_valid;
  logic        acc_write;
  logic [4:0]  acc_addr;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata;
  logic [1:0]  hdlc_fifo_stb;
  logic [1:0]  hdlc_ctl_stb;
  logic        xcv_lo_stb, xcv_hi_stb, xcv_fifo_stb, card_stb;
  logic [3:0]  unit_off;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model
  logic [7:0]  m_idx;
  logic [7:0]  m_card [2];
  logic [31:0] m_hfifo [2];
  logic [31:0] m_hctl [2];
  logic [7:0]  m_xlo [16];
  logic [7:0]  m_xhi [16];
  logic [7:0]  m_xfifo;

  always #4 clk = ~clk;

  iowin_decoder uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .flat_map      (flat_map),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_addr      (acc_addr),
    .acc_wdata     (acc_wdata),
    .acc_rdata     (acc_rdata),
    .hdlc_fifo_stb (hdlc_fifo_stb),
    .hdlc_ctl_stb  (hdlc_ctl_stb),
    .xcv_lo_stb    (xcv_lo_stb),
    .xcv_hi_stb    (xcv_hi_stb),
    .xcv_fifo_stb  (xcv_fifo_stb),
    .card_stb      (card_stb),
    .unit_off      (unit_off)
  );

  // unit codes: 0 none, 1 card, 2 h1 fifo, 3 h1 ctl, 4 h2 fifo, 5 h2 ctl,
  // 6 xcv low, 7 xcv high, 8 xcv fifo, 9 index register
  function automatic int exp_unit(input logic fl, input logic [4:0] a,
                                  input logic [7:0] ix, output logic [3:0] o);
    int r = 0;
    o = 4'd0;
    if (a == 5'd2 || a == 5'd3) begin
      r = 1; o = a[3:0];
    end else if (a == 5'd4) begin
      r = 9;
    end else if (fl) begin
      case (a)
        5'd8:  begin r = (ix >= 8'h30) ? 7 : 6; o = ix[3:0]; end
        5'd16: r = 2;
        5'd20: begin r = 3; o = 4'd4; end
        5'd24: r = 4;
        5'd28: begin r = 5; o = 4'd4; end
        default: r = 0;
      endcase
    end else if (a >= 5'd16) begin
      case (ix)
        8'h00: r = (a[3:0] == 0) ? 2 : (a[3:0] == 4) ? 3 : 0;
        8'h01: r = (a[3:0] == 0) ? 4 : (a[3:0] == 4) ? 5 : 0;
        8'h02: r = 8;
        8'h04: r = 6;
        8'h06: r = 7;
        default: r = 0;
      endcase
      if (r != 0) o = a[3:0];
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input int u, input logic [3:0] o);
    case (u)
      1: return {24'h0, m_card[o[0]]};
      2: return m_hfifo[0];
      3: return m_hctl[0];
      4: return m_hfifo[1];
      5: return m_hctl[1];
      6: return {24'h0, m_xlo[o]};
      7: return {24'h0, m_xhi[o]};
      8: return {24'h0, m_xfifo};
      9: return {24'h0, m_idx};
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [7:0] exp_strobes(input int u);
    logic [7:0] s = 8'h00;
    if (u >= 1 && u <= 8) s[u-1] = 1'b1;
    return s;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_write(input int u, input logic [3:0] o, input logic [31:0] d);
    case (u)
      1: m_card[o[0]] = d[7:0];
      2: m_hfifo[0]   = d;
      3: m_hctl[0]    = d;
      4: m_hfifo[1]   = d;
      5: m_hctl[1]    = d;
      6: m_xlo[o]     = d[7:0];
      7: m_xhi[o]     = d[7:0];
      8: m_xfifo      = d[7:0];
      9: m_idx        = d[7:0];
      default: ;
    endcase
  endtask

  // one access; strobes/offset always checked under R10, read data under req
  task automatic access(input logic fl, input logic we, input logic [4:0] a,
                        input logic [31:0] d, input string req);
    int u;
    logic [3:0] o;
    logic [7:0] obs;
    @(negedge clk);
    flat_map  = fl;
    acc_valid = 1'b1;
    acc_write = we;
    acc_addr  = a;
    acc_wdata = d;
    #1;
    u   = exp_unit(fl, a, m_idx, o);
    obs = {xcv_fifo_stb, xcv_hi_stb, xcv_lo_stb, hdlc_ctl_stb[1], hdlc_fifo_stb[1],
           hdlc_ctl_stb[0], hdlc_fifo_stb[0], card_stb};
    chk("R10", "strobes", {24'h0, obs}, {24'h0, exp_strobes(u)});
    chk("R10", "unit_off", {28'h0, unit_off}, {28'h0, o});
    if (!we) chk(req, "rdata", acc_rdata, exp_read(u, o));
    @(posedge clk);
    #1;
    acc_valid = 1'b0;
    acc_write = 1'b0;
    if (we) model_write(u, o, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20931));
    rst_n = 1'b0; flat_map = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
    acc_addr = '0; acc_wdata = '0;
    m_idx = 8'h00; m_xfifo = 8'h00;
    for (int i = 0; i < 2; i++) begin m_card[i] = 8'h00; m_hfifo[i] = '0; m_hctl[i] = '0; end
    for (int i = 0; i < 16; i++) begin m_xlo[i] = 8'h00; m_xhi[i] = 8'h00; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    access(1'b0, 1'b0, 5'h04, 32'h0, "R1");
    access(1'b0, 1'b0, 5'h02, 32'h0, "R1");
    access(1'b0, 1'b0, 5'h10, 32'h0, "R1");
    access(1'b1, 1'b0, 5'h1C, 32'h0, "R1");

    // R2: index write/readback, upper bits dropped
    access(1'b0, 1'b1, 5'h04, 32'hABCD_EF06, "R2");
    access(1'b0, 1'b0, 5'h04, 32'h0, "R2");
    access(1'b1, 1'b1, 5'h04, 32'h1234_5600, "R2");
    access(1'b1, 1'b0, 5'h04, 32'h0, "R2");

    // R3: HDLC channels through the window
    access(1'b0, 1'b1, 5'h10, 32'hA1A1_0001, "R3");
    access(1'b0, 1'b1, 5'h14, 32'hC1C1_0002, "R3");
    access(1'b0, 1'b1, 5'h04, 32'h0000_0001, "R3");
    access(1'b0, 1'b1, 5'h10, 32'hA2A2_0003, "R3");
    access(1'b0, 1'b1, 5'h14, 32'hC2C2_0004, "R3");
    access(1'b0, 1'b0, 5'h10, 32'h0, "R3");
    access(1'b0, 1'b0, 5'h14, 32'h0, "R3");
    access(1'b0, 1'b1, 5'h04, 32'h0000_0000, "R3");
    access(1'b0, 1'b0, 5'h10, 32'h0, "R3");
    access(1'b0, 1'b0, 5'h14, 32'h0, "R3");

    // R6: stray HDLC offsets and unassigned pages
    access(1'b0, 1'b1, 5'h11, 32'hDEAD_BEEF, "R6");
    access(1'b0, 1'b1, 5'h18, 32'hDEAD_BEEF, "R6");
    access(1'b0, 1'b0, 5'h18, 32'h0, "R6");
    access(1'b0, 1'b0, 5'h10, 32'h0, "R6");
    access(1'b0, 1'b0, 5'h08, 32'h0, "R6");
    access(1'b0, 1'b0, 5'h00, 32'h0, "R6");
    access(1'b0, 1'b1, 5'h04, 32'h0000_0003, "R6");
    access(1'b0, 1'b1, 5'h10, 32'h5555_5555, "R6");
    access(1'b0, 1'b0, 5'h10, 32'h0, "R6");
    access(1'b0, 1'b1, 5'h04, 32'h0000_0005, "R6");
    access(1'b0, 1'b0, 5'h17, 32'h0, "R6");

    // R4: transceiver FIFO at any window offset
    access(1'b0, 1'b1, 5'h04, 32'h0000_0002, "R4");
    access(1'b0, 1'b1, 5'h17, 32'hFFFF_FF3C, "R4");
    access(1'b0, 1'b0, 5'h1B, 32'h0, "R4");
    access(1'b0, 1'b0, 5'h10, 32'h0, "R4");

    // R5: low and high pages are separate
    access(1'b0, 1'b1, 5'h04, 32'h0000_0004, "R5");
    access(1'b0, 1'b1, 5'h13, 32'h0000_005A, "R5");
    access(1'b0, 1'b1, 5'h1F, 32'h0000_00F0, "R5");
    access(1'b0, 1'b1, 5'h04, 32'h0000_0006, "R5");
    access(1'b0, 1'b1, 5'h13, 32'h0000_00A5, "R5");
    access(1'b0, 1'b0, 5'h13, 32'h0, "R5");
    access(1'b0, 1'b1, 5'h04, 32'h0000_0004, "R5");
    access(1'b0, 1'b0, 5'h13, 32'h0, "R5");
    access(1'b0, 1'b0, 5'h1F, 32'h0, "R5");

    // R7: flat HDLC ports ignore the index (index currently 0x04)
    access(1'b1, 1'b0, 5'h10, 32'h0, "R7");
    access(1'b1, 1'b0, 5'h14, 32'h0, "R7");
    access(1'b1, 1'b0, 5'h18, 32'h0, "R7");
    access(1'b1, 1'b0, 5'h1C, 32'h0, "R7");
    access(1'b1, 1'b1, 5'h18, 32'h7777_0018, "R7");
    access(1'b1, 1'b0, 5'h12, 32'h0, "R7");
    access(1'b0, 1'b1, 5'h04, 32'h0000_0001, "R7");
    access(1'b0, 1'b0, 5'h10, 32'h0, "R7");

    // R8: flat transceiver access, page boundary at 0x2F/0x30
    access(1'b1, 1'b1, 5'h04, 32'h0000_0023, "R8");
    access(1'b1, 1'b0, 5'h08, 32'h0, "R8");
    access(1'b1, 1'b1, 5'h04, 32'h0000_0033, "R8");
    access(1'b1, 1'b0, 5'h08, 32'h0, "R8");
    access(1'b1, 1'b1, 5'h04, 32'h0000_002F, "R8");
    access(1'b1, 1'b1, 5'h08, 32'hFFFF_FF11, "R8");
    access(1'b1, 1'b0, 5'h08, 32'h0, "R8");
    access(1'b1, 1'b1, 5'h04, 32'h0000_0030, "R8");
    access(1'b1, 1'b1, 5'h08, 32'hABCD_EF22, "R8");
    access(1'b1, 1'b0, 5'h08, 32'h0, "R8");
    access(1'b1, 1'b1, 5'h04, 32'h0000_003F, "R8");
    access(1'b1, 1'b0, 5'h08, 32'h0, "R8");
    access(1'b0, 1'b1, 5'h04, 32'h0000_0004, "R8");
    access(1'b0, 1'b0, 5'h1F, 32'h0, "R8");
    access(1'b0, 1'b1, 5'h04, 32'h0000_0006, "R8");
    access(1'b0, 1'b0, 5'h10, 32'h0, "R8");

    // R9: card bytes in both modes
    access(1'b1, 1'b1, 5'h03, 32'h0000_0099, "R9");
    access(1'b0, 1'b1, 5'h02, 32'hFFFF_FF42, "R9");
    access(1'b0, 1'b0, 5'h03, 32'h0, "R9");
    access(1'b1, 1'b0, 5'h02, 32'h0, "R9");

    // random mix, R10 on every access plus routed read data
    for (int n = 0; n < 3000; n++) begin
      logic        fl;
      logic        we;
      logic [4:0]  a;
      logic [31:0] d;
      int          pick;
      fl   = ($urandom % 4) == 0;
      we   = ($urandom % 2) == 1;
      d    = $urandom;
      pick = $urandom % 10;
      if (pick < 2) a = 5'h04;
      else if (pick < 7) a = 5'h10 | 5'($urandom % 16);
      else a = 5'($urandom % 32);
      if (a == 5'h04 && we) begin
        case ($urandom % 10)
          0: d[7:0] = 8'h00; 1: d[7:0] = 8'h01; 2: d[7:0] = 8'h02;
          3: d[7:0] = 8'h04; 4: d[7:0] = 8'h06; 5: d[7:0] = 8'h03;
          6: d[7:0] = 8'h2F; 7: d[7:0] = 8'h30;
          default: d[7:0] = 8'($urandom % 64);
        endcase
      end
      access(fl, we, a, d, "R6");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule